// File: doc/BRIEF.md
# Iterative Shift-and-Add Integer Multiplier

This block multiplies two 32-bit operands over many clock cycles and returns a 64-bit product split into an upper and a lower 32-bit word, so it can act as the multiply unit behind a processor's paired result registers. A client raises `start` with the operands and a signedness flag while the unit is idle. The unit then reports `busy`, works through the multiplier one bit per cycle and finally raises `done` for one cycle, with the new words on `prod_hi` and `prod_lo`.

Inside, the multiplicand sits in a double-width register that moves one place left each step. The multiplier sits in a single-width register that moves one place right, so its lowest bit always decides whether the current multiplicand image is added to the accumulator. In signed mode both operands are replaced by their magnitudes before the loop. The sign is restored by a two's complement negation of the whole 64-bit result when exactly one operand was negative.

Top module: `seq_mul`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `busy` and `done` are 0 and `prod_hi`/`prod_lo` are both zero.
- R2: A clock edge that sees `start`=1 while `busy`=0 accepts the operands and `sign_mode`. `busy` is 1 in the 33 cycles that follow that edge and 0 again after the 33rd edge following it.
- R3: `done` is 1 for exactly one cycle, directly after the 33rd edge following the accepting edge, and is never 1 while `busy` is 1.
- R4: With `sign_mode`=0 the result {`prod_hi`,`prod_lo`} is the unsigned 64-bit product of `mcand` and `mplier`, including zero and all-ones operands.
- R5: With `sign_mode`=1 the operands are two's complement and the result is the signed 64-bit product, including operands equal to -2^31.
- R6: `start`, `mcand`, `mplier` and `sign_mode` are ignored while `busy`=1. The running multiply keeps its timing and its result.
- R7: `prod_hi` and `prod_lo` keep the previous result from the cycle after `done` until the next `done`. This includes the whole time a later multiply runs.
- R8: A `start` seen in the cycle in which `done` is 1 is accepted, so a new multiply begins back to back with the last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a multiply; taken only when idle |
| sign_mode | input | 1 | 1: operands are two's complement, 0: unsigned |
| mcand | input | 32 | Multiplicand |
| mplier | input | 32 | Multiplier |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle pulse: result words just updated |
| prod_hi | output | 32 | Upper word of the last product |
| prod_lo | output | 32 | Lower word of the last product |

## Verification
The delicate coincidence is the completion pulse and a fresh request falling in the same cycle. The cycle before `done` is still busy, while the `done` cycle itself is idle. The bench holds `start` high without a break across a whole multiply and changes the operands partway through. It then requires the first result to match the original operands and `done` to appear exactly 33 edges after acceptance. It also requires a second multiply, carrying the operands presented in the `done` cycle, to finish exactly 33 edges after that.

// File: rtl/mul_pkg.sv
package mul_pkg;

    localparam int unsigned OP_W   = 32;
    localparam int unsigned PROD_W = 2 * OP_W;
    localparam int unsigned CNT_W  = $clog2(OP_W);

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_FIN  = 2'd2
    } mul_state_e;

    typedef struct packed {
        logic [PROD_W-1:0] mcand_sh;
        logic [OP_W-1:0]   mplier_sh;
        logic [PROD_W-1:0] acc;
        logic              neg;
    } mul_dp_t;

    // magnitude of an operand; unsigned mode passes it through
    function automatic logic [OP_W-1:0] op_mag(input logic [OP_W-1:0] v, input logic sgn);
        return (sgn && v[OP_W-1]) ? (~v + 1'b1) : v;
    endfunction

    function automatic logic [PROD_W-1:0] apply_sign(input logic [PROD_W-1:0] v, input logic neg);
        return neg ? (~v + 1'b1) : v;
    endfunction

endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
    import mul_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic step,
    output logic fin,
    output logic busy
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(OP_W - 1);

    mul_state_e       state;
    logic [CNT_W-1:0] cnt;

    assign busy = (state != S_IDLE);
    assign load = (state == S_IDLE) && start;
    assign step = (state == S_RUN);
    assign fin  = (state == S_FIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    state <= S_RUN;
                    cnt   <= '0;
                end
                S_RUN: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) state <= S_FIN;
                end
                S_FIN:   state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // R2
    run_len_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_RUN && cnt != LAST) |=> (state == S_RUN));

    // R6
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_RUN && start && cnt != LAST) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/mul_datapath.sv
module mul_datapath
    import mul_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [OP_W-1:0]   mag_a,
    input  logic [OP_W-1:0]   mag_b,
    input  logic              neg_in,
    output logic [PROD_W-1:0] acc,
    output logic              neg
);

    mul_dp_t dp;

    always_ff @(posedge clk) begin
        if (rst) begin
            dp <= '0;
        end else if (load) begin
            dp.mcand_sh  <= {{OP_W{1'b0}}, mag_a};
            dp.mplier_sh <= mag_b;
            dp.acc       <= '0;
            dp.neg       <= neg_in;
        end else if (step) begin
            if (dp.mplier_sh[0]) dp.acc <= dp.acc + dp.mcand_sh;
            dp.mcand_sh  <= dp.mcand_sh << 1;
            dp.mplier_sh <= dp.mplier_sh >> 1;
        end
    end

    assign acc = dp.acc;
    assign neg = dp.neg;

    // R4
    acc_grow_chk: assert property (@(posedge clk) disable iff (rst)
        step |=> (dp.acc >= $past(dp.acc)));

endmodule

// File: rtl/mul_sign.sv
module mul_sign
    import mul_pkg::*;
(
    input  logic              sign_mode,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    output logic [OP_W-1:0]   mag_a,
    output logic [OP_W-1:0]   mag_b,
    output logic              neg_out,
    input  logic [PROD_W-1:0] raw,
    input  logic              neg_q,
    output logic [PROD_W-1:0] fixed
);

    always_comb begin
        mag_a   = op_mag(op_a, sign_mode);
        mag_b   = op_mag(op_b, sign_mode);
        neg_out = sign_mode && (op_a[OP_W-1] ^ op_b[OP_W-1]);
        fixed   = apply_sign(raw, neg_q);
    end

endmodule

// File: rtl/seq_mul.sv
module seq_mul
    import mul_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            sign_mode,
    input  logic [OP_W-1:0] mcand,
    input  logic [OP_W-1:0] mplier,
    output logic            busy,
    output logic            done,
    output logic [OP_W-1:0] prod_hi,
    output logic [OP_W-1:0] prod_lo
);

    logic              load, step, fin;
    logic [OP_W-1:0]   mag_a, mag_b;
    logic              neg_in, neg_q;
    logic [PROD_W-1:0] acc, fixed, result;

    mul_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .load(load), .step(step), .fin(fin), .busy(busy)
    );

    mul_sign u_sign (
        .sign_mode(sign_mode), .op_a(mcand), .op_b(mplier),
        .mag_a(mag_a), .mag_b(mag_b), .neg_out(neg_in),
        .raw(acc), .neg_q(neg_q), .fixed(fixed)
    );

    mul_datapath u_dp (
        .clk(clk), .rst(rst), .load(load), .step(step),
        .mag_a(mag_a), .mag_b(mag_b), .neg_in(neg_in),
        .acc(acc), .neg(neg_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= fin;
            if (fin) result <= fixed;
        end
    end

    assign prod_hi = result[PROD_W-1:OP_W];
    assign prod_lo = result[OP_W-1:0];

    // R3
    done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !done) |-> $stable({prod_hi, prod_lo}));

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

endmodule

// File: tb/test_seq_mul.sv
module test_seq_mul;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        sign_mode = 1'b0;
    logic [31:0] mcand = '0;
    logic [31:0] mplier = '0;
    logic        busy, done;
    logic [31:0] prod_hi, prod_lo;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    seq_mul i_seq_mul (
        .clk(clk), .rst(rst), .start(start), .sign_mode(sign_mode),
        .mcand(mcand), .mplier(mplier), .busy(busy), .done(done),
        .prod_hi(prod_hi), .prod_lo(prod_lo)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_prod(input logic [31:0] a, input logic [31:0] b, input logic s);
        longint sa, sb;
        if (s) begin
            sa = longint'($signed(a));
            sb = longint'($signed(b));
            return 64'(sa * sb);
        end
        return {32'b0, a} * {32'b0, b};
    endfunction

    // waits for done at falling edges; returns edges counted after the accepting edge
    task automatic wait_done(output int edges);
        edges = 0;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (done) begin edges = k; break; end
        end
    endtask

    task automatic run_one(input logic [31:0] a, input logic [31:0] b, input logic s, input string req);
        int e;
        @(negedge clk);
        mcand = a; mplier = b; sign_mode = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R2", "busy after accept", 64'(busy), 64'd1);
        wait_done(e);
        check(e == 33, "R3", "done latency", 64'(e), 64'd33);
        check({prod_hi, prod_lo} === ref_prod(a, b, s), req, "product",
              {prod_hi, prod_lo}, ref_prod(a, b, s));
        @(negedge clk);
        check(done === 1'b0, "R3", "done width", 64'(done), 64'd0);
    endtask

    task automatic t_reset();
        check(busy === 1'b0 && done === 1'b0, "R1", "flags in reset", {62'b0, busy, done}, 64'd0);
        check({prod_hi, prod_lo} === 64'd0, "R1", "result in reset", {prod_hi, prod_lo}, 64'd0);
    endtask

    task automatic t_unsigned();
        run_one(32'd7, 32'd9, 1'b0, "R4");
        run_one(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R4");
        run_one(32'd0, 32'h1234_5678, 1'b0, "R4");
        run_one(32'h8000_0000, 32'd2, 1'b0, "R4");
        run_one(32'hDEAD_BEEF, 32'h0BAD_F00D, 1'b0, "R4");
    endtask

    task automatic t_signed();
        run_one(32'hFFFF_FFFD, 32'd5, 1'b1, "R5");
        run_one(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R5");
        run_one(32'h8000_0000, 32'h8000_0000, 1'b1, "R5");
        run_one(32'h8000_0000, 32'd1, 1'b1, "R5");
        run_one(32'd123_456, 32'hFFF0_0000, 1'b1, "R5");
        run_one(32'h7FFF_FFFF, 32'h8000_0000, 1'b1, "R5");
    endtask

    task automatic t_hold();
        logic [63:0] prev;
        run_one(32'd1000, 32'd3000, 1'b0, "R4");
        prev = {prod_hi, prod_lo};
        @(negedge clk);
        mcand = 32'd5; mplier = 32'd6; sign_mode = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        check({prod_hi, prod_lo} === prev, "R7", "old result held while busy", {prod_hi, prod_lo}, prev);
        begin
            int e;
            wait_done(e);
            check({prod_hi, prod_lo} === 64'd30, "R7", "new result at done", {prod_hi, prod_lo}, 64'd30);
        end
    endtask

    task automatic t_overlap();
        int e;
        @(negedge clk);
        mcand = 32'hFFFF_FFF0; mplier = 32'd3; sign_mode = 1'b1; start = 1'b1;
        @(negedge clk);
        // R6: present other operands and mode while busy, start kept high
        mcand = 32'd11; mplier = 32'd13; sign_mode = 1'b0;
        wait_done(e);
        check(e == 33, "R6", "latency with start held", 64'(e), 64'd33);
        check({prod_hi, prod_lo} === ref_prod(32'hFFFF_FFF0, 32'd3, 1'b1), "R6", "first operands kept",
              {prod_hi, prod_lo}, ref_prod(32'hFFFF_FFF0, 32'd3, 1'b1));
        // R8: start still high in the done cycle
        mcand = 32'h0001_0000; mplier = 32'h0002_0000; sign_mode = 1'b0;
        @(negedge clk);
        check(busy === 1'b1, "R8", "back-to-back accept", 64'(busy), 64'd1);
        start = 1'b0;
        wait_done(e);
        check(e == 33, "R8", "second latency", 64'(e + 0), 64'd33);
        check({prod_hi, prod_lo} === 64'h0000_0002_0000_0000, "R8", "second product",
              {prod_hi, prod_lo}, 64'h0000_0002_0000_0000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_unsigned();
        t_signed();
        t_hold();
        t_overlap();
        repeat (3) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule